// File: doc/BRIEF.md
# GPIO Alarm Register Block

This block holds the control and status registers for five general-purpose pins and one transmit-fault input. A register read/write port sits behind a management front end that decodes a device number and a 16-bit register address. It sees four consecutive registers in device 1, starting at 0xC010. For each pin, the block sets the direction and the driven level. It exposes the pin tri-state controls (`pin_oe`) and levels (`pin_out`) to the pad ring.

Input pins are brought into the clock domain through a two-flop synchronizer. Each synchronized pin is XORed with a per-pin invert bit, and the result is captured in a latched-high alarm bit. A pin contributes to the single alarm interrupt output only when three conditions hold: its latched alarm bit is set, its own enable bit is set, and the global GPIO alarm enable input is high. The synchronized transmit-fault input, corrected by a polarity bit, adds one more term. The alarm interrupt is the registered OR of all these terms.

Top module: `gpio_alarm_regs`

## Requirements
- R1: After reset, every register field is 0, `pin_oe` and `pin_out` are 0, `alarm_irq` is 0, and every register reads 0 while all inputs are low.
- R2: The direction register at 0xC010 stores bits 4:0 on a write (1 = output, 0 = input) and reads them back. `pin_oe` equals those bits from the cycle after the write.
- R3: The output-level register at 0xC013 stores bits 4:0 on a write (1 = high, 0 = low) and reads them back. `pin_out` equals those bits from the cycle after the write.
- R4: Bits 4:0 of the input status register at 0xC011 show `pin_in` after two clock edges of synchronization. The same bit positions apply.
- R5: Bits 12:8 of the status register show latched alarm bits. Bit 8+i is set on the clock edge after synchronized pin i XOR invert bit i reads 1. Once set, it stays set until a read of the status register.
- R6: A read of the status register returns the value held before the read. On the edge that ends the read, each latched bit is cleared only if its corrected input is 0 at that edge.
- R7: The alarm configuration register at 0xC012 holds three fields: per-pin alarm enable in bits 4:0, per-pin invert in bits 12:8, and transmit-fault polarity in bit 13. All three read back.
- R8: The transmit-fault term is the synchronized `txflt_in` when the polarity bit is 0, and its inverse when the polarity bit is 1. This term is not gated by `glb_en`.
- R9: `alarm_irq` is registered. It is 1 exactly when, on the previous edge, the transmit-fault term was 1 or some pin had its latched bit, its enable bit and `glb_en` all at 1.
- R10: Writes to the status register, to reserved bits (15:5 of direction and output, 15:14 and 7:5 of configuration), to other addresses or to other devices are ignored. Reserved bits read 0.
- R11: A read of an address outside the four registers, or of a device other than 1, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_dev | input | 5 | Device number of the access |
| reg_addr | input | 16 | Register address of the access |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; clears status latches at its edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| pin_in | input | 5 | Raw pin levels from the pads |
| pin_out | output | 5 | Levels driven on output pins |
| pin_oe | output | 5 | Output enable per pin (1 = drive) |
| txflt_in | input | 1 | Transmit-fault input |
| glb_en | input | 1 | Global GPIO alarm enable |
| alarm_irq | output | 1 | Alarm interrupt output |

## Verification
A corrupted invert or enable field appears at `alarm_irq` one edge after the affected latched bit is set. A wrong read-back of the configuration register exposes it at once. A latched bit that is lost or stuck shows in the next status read. It also shows at `alarm_irq` within one cycle when that pin is enabled and `glb_en` is high. A synchronizer with the wrong depth shifts the raw status bits one cycle early or late, and the directed reads catch this at edge granularity.

// File: rtl/gpio_alarm_regs.sv
module gpio_alarm_regs #(
  parameter int          NPIN     = 5,
  parameter logic [4:0]  DEV_ID   = 5'd1,
  parameter logic [15:0] BASE     = 16'hC010,
  parameter int          INV_LSB  = 8,
  parameter int          POL_BIT  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_dev,
  input  logic [15:0] reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [4:0]  pin_in,
  output logic [4:0]  pin_out,
  output logic [4:0]  pin_oe,
  input  logic        txflt_in,
  input  logic        glb_en,
  output logic        alarm_irq
);

  localparam logic [15:0] A_DIR  = BASE;
  localparam logic [15:0] A_STAT = BASE + 16'd1;
  localparam logic [15:0] A_CFG  = BASE + 16'd2;
  localparam logic [15:0] A_OUT  = BASE + 16'd3;

  logic [NPIN-1:0] dir_q, out_q, inv_q, en_q;
  logic            txpol_q;
  logic [NPIN-1:0] pin_s1, pin_s2, stat_lh;
  logic            tx_s1, tx_s2;
  logic [NPIN-1:0] corr;
  logic            tx_term;
  logic            dev_hit, wr_dir, wr_cfg, wr_out, rd_stat;

  assign dev_hit = (reg_dev == DEV_ID);
  assign wr_dir  = reg_wr && dev_hit && (reg_addr == A_DIR);
  assign wr_cfg  = reg_wr && dev_hit && (reg_addr == A_CFG);
  assign wr_out  = reg_wr && dev_hit && (reg_addr == A_OUT);
  assign rd_stat = reg_rd && dev_hit && (reg_addr == A_STAT);

  assign corr    = pin_s2 ^ inv_q;
  assign tx_term = tx_s2 ^ txpol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
      tx_s1  <= 1'b0;
      tx_s2  <= 1'b0;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
      tx_s1  <= txflt_in;
      tx_s2  <= tx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      inv_q   <= '0;
      en_q    <= '0;
      txpol_q <= 1'b0;
    end else begin
      if (wr_dir) dir_q <= reg_wdata[NPIN-1:0];
      if (wr_out) out_q <= reg_wdata[NPIN-1:0];
      if (wr_cfg) begin
        en_q    <= reg_wdata[NPIN-1:0];
        inv_q   <= reg_wdata[INV_LSB +: NPIN];
        txpol_q <= reg_wdata[POL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_lh <= '0;
    else if (rd_stat) stat_lh <= corr;
    else stat_lh <= stat_lh | corr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_irq <= 1'b0;
    else alarm_irq <= (glb_en && |(stat_lh & en_q)) || tx_term;
  end

  always_comb begin
    reg_rdata = '0;
    if (dev_hit) begin
      case (reg_addr)
        A_DIR:  reg_rdata[NPIN-1:0] = dir_q;
        A_OUT:  reg_rdata[NPIN-1:0] = out_q;
        A_STAT: begin
          reg_rdata[NPIN-1:0]        = pin_s2;
          reg_rdata[INV_LSB +: NPIN] = stat_lh;
        end
        A_CFG: begin
          reg_rdata[NPIN-1:0]        = en_q;
          reg_rdata[INV_LSB +: NPIN] = inv_q;
          reg_rdata[POL_BIT]         = txpol_q;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;

endmodule

module gpio_alarm_regs_chk #(
  parameter logic [4:0]  DEV_ID = 5'd1,
  parameter logic [15:0] BASE   = 16'hC010
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_dev,
  input logic [15:0] reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [4:0]  pin_in,
  input logic [4:0]  pin_oe,
  input logic        glb_en,
  input logic        alarm_irq,
  input logic [4:0]  raw,
  input logic [4:0]  lh,
  input logic        tx_s,
  input logic        tx_pol
);
  logic [1:0] cyc;
  logic       rd_st, wr_d, tx_on;
  assign rd_st = reg_rd && reg_dev == DEV_ID && reg_addr == BASE + 16'd1;
  assign wr_d  = reg_wr && reg_dev == DEV_ID && reg_addr == BASE;
  assign tx_on = tx_s != tx_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_d |=> pin_oe == $past(reg_wdata[4:0]));

  assert_raw_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc >= 2'd2 |-> raw == $past(pin_in, 2));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_st) |-> (lh & $past(lh)) == $past(lh));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !$past(tx_on)) |-> $past(glb_en));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_dev == DEV_ID && (reg_addr == BASE || reg_addr == BASE + 16'd3))
      |-> reg_rdata[15:5] == 11'd0);
endmodule

bind gpio_alarm_regs gpio_alarm_regs_chk #(.DEV_ID(DEV_ID), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_dev(reg_dev), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_in(pin_in), .pin_oe(pin_oe), .glb_en(glb_en), .alarm_irq(alarm_irq),
  .raw(pin_s2), .lh(stat_lh), .tx_s(tx_s2), .tx_pol(txpol_q)
);

// File: tb/gpio_alarm_regs_tb.sv
module gpio_alarm_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  reg_dev = 5'd1;
  logic [15:0] reg_addr = 16'h0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [4:0]  pin_in = 5'h0;
  logic [4:0]  pin_out, pin_oe;
  logic        txflt_in = 0, glb_en = 0, alarm_irq;
  int checks = 0, errors = 0;
  logic done = 0;

  localparam logic [15:0] DIR = 16'hC010, STAT = 16'hC011, CFG = 16'hC012, OUTR = 16'hC013;

  always #2.5 clk = ~clk;

  gpio_alarm_regs u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] dev, input logic [15:0] a, input logic [15:0] d);
    reg_dev = dev; reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0; reg_dev = 5'd1;
  endtask

  task automatic rd(input logic [4:0] dev, input logic [15:0] a, output logic [15:0] d);
    reg_dev = dev; reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    tick(1);
    reg_rd = 0; reg_dev = 5'd1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1, DIR, v);  chk("R1 dir", v, 0);
    rd(1, STAT, v); chk("R1 stat", v, 0);
    rd(1, CFG, v);  chk("R1 cfg", v, 0);
    rd(1, OUTR, v); chk("R1 out", v, 0);
    chk("R1 pins", {6'd0, alarm_irq, pin_oe, pin_out}, 0);
  endtask

  task automatic t_dir_out;
    logic [15:0] v;
    wr(1, DIR, 16'hFFFF);
    chk("R2 oe", {11'd0, pin_oe}, 16'h001F);
    rd(1, DIR, v); chk("R2/R10 dir readback", v, 16'h001F);
    wr(1, DIR, 16'h000A);
    chk("R2 oe pattern", {11'd0, pin_oe}, 16'h000A);
    wr(1, OUTR, 16'hFFF5);
    chk("R3 pin_out", {11'd0, pin_out}, 16'h0015);
    rd(1, OUTR, v); chk("R3 out readback", v, 16'h0015);
  endtask

  task automatic t_cfg;
    logic [15:0] v;
    wr(1, CFG, 16'hFFFF);
    rd(1, CFG, v); chk("R7 cfg readback", v, 16'h3F1F);
    wr(1, CFG, 16'h2A05);
    rd(1, CFG, v); chk("R7 cfg pattern", v, 16'h2A05);
    wr(1, CFG, 16'h0000);
    tick(2);
    rd(1, STAT, v);
    rd(1, STAT, v); chk("R7 cfg cleared status", v, 0);
  endtask

  task automatic t_ignore;
    logic [15:0] v;
    wr(1, STAT, 16'hFFFF);
    rd(1, STAT, v); chk("R10 status write ignored", v, 0);
    wr(5'd3, DIR, 16'h001F);
    chk("R10 other device write", {11'd0, pin_oe}, 16'h000A);
    wr(1, 16'hC014, 16'h001F);
    rd(1, DIR, v); chk("R10 other address write", v, 16'h000A);
    rd(5'd3, DIR, v); chk("R11 other device read", v, 0);
    rd(1, 16'hC014, v); chk("R11 other address read", v, 0);
  endtask

  task automatic t_raw_latch;
    logic [15:0] v;
    pin_in = 5'b10110;
    tick(1);
    rd(1, STAT, v); chk("R4 raw after one edge", v, 16'h0000);
    rd(1, STAT, v); chk("R4 raw after two edges", v, 16'h0016);
    rd(1, STAT, v); chk("R5 latch set", v, 16'h1616);
    pin_in = 5'b00000;
    tick(2);
    rd(1, STAT, v); chk("R5 latch holds", v, 16'h1600);
    rd(1, STAT, v); chk("R6 cleared after read", v, 16'h0000);
  endtask

  task automatic t_persist;
    logic [15:0] v;
    pin_in = 5'b00001;
    tick(3);
    rd(1, STAT, v); chk("R6 first read", v, 16'h0101);
    rd(1, STAT, v); chk("R6 not cleared while present", v, 16'h0101);
    pin_in = 5'b00000;
    tick(2);
    rd(1, STAT, v); chk("R6 pre-clear value", v, 16'h0100);
    rd(1, STAT, v); chk("R6 cleared", v, 16'h0000);
  endtask

  task automatic t_invert;
    logic [15:0] v;
    wr(1, CFG, 16'h0300);
    tick(1);
    rd(1, STAT, v); chk("R5 inverted low pins latch", v, 16'h0300);
    pin_in = 5'b00011;
    tick(2);
    rd(1, STAT, v); chk("R5 invert raw and latch", v, 16'h0303);
    rd(1, STAT, v); chk("R6 inverted clear", v, 16'h0003);
    pin_in = 5'b00000;
    wr(1, CFG, 16'h0000);
    tick(2);
    rd(1, STAT, v);
    rd(1, STAT, v); chk("R5 invert cleanup", v, 0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(1, CFG, 16'h0004);
    pin_in = 5'b00100;
    tick(5);
    chk("R9 gated by glb_en", {15'd0, alarm_irq}, 0);
    glb_en = 1;
    tick(1);
    chk("R9 irq raised", {15'd0, alarm_irq}, 1);
    wr(1, CFG, 16'h0001);
    tick(1);
    chk("R9 other pin enabled only", {15'd0, alarm_irq}, 0);
    wr(1, CFG, 16'h0004);
    tick(1);
    chk("R9 re-enabled", {15'd0, alarm_irq}, 1);
    glb_en = 0;
    tick(1);
    chk("R9 glb_en drop", {15'd0, alarm_irq}, 0);
    pin_in = 5'b00000;
    wr(1, CFG, 16'h0000);
    tick(2);
    rd(1, STAT, v);
    rd(1, STAT, v); chk("R9 cleanup", v, 0);
  endtask

  task automatic t_tx;
    txflt_in = 1;
    tick(2);
    chk("R9 tx not yet", {15'd0, alarm_irq}, 0);
    tick(1);
    chk("R8 tx high active", {15'd0, alarm_irq}, 1);
    wr(1, CFG, 16'h2000);
    tick(1);
    chk("R8 polarity flips off", {15'd0, alarm_irq}, 0);
    txflt_in = 0;
    tick(3);
    chk("R8 tx low active", {15'd0, alarm_irq}, 1);
    wr(1, CFG, 16'h0000);
    tick(1);
    chk("R8 polarity restored", {15'd0, alarm_irq}, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_dir_out();
    t_cfg();
    t_ignore();
    t_raw_latch();
    t_persist();
    t_invert();
    t_irq();
    t_tx();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule